// File: doc/BRIEF.md
# Page-Erase Row-Program Flash Array Model

This block is a synthesizable behavioural model of an embedded flash array. The storage is built from ordinary on-chip registers. It supports three operations:

- **Byte reads** through a combinational read port.
- **Erase** of a whole page to all ones.
- **Program** of a whole row from a row-wide write buffer with one enable per byte.

Flash semantics are enforced. Erase drives every bit of the selected page to 1. Programming can only pull bits from 1 to 0, because the buffered data is ANDed into the stored bytes.

A host starts an operation with a one-cycle erase or program strobe and a target address. The model accepts the command and raises busy for a fixed number of cycles. It then applies the change to the whole aligned unit in a single clock edge and pulses done. While busy is high, reads return 0xFF and any further strobes are dropped. A strobe whose address lies beyond the array is refused and flagged.

The default build holds 512 bytes (8 pages of two 32-byte rows). Any multiple of the page size up to the address space is legal, including a 15,872-byte array.

Top module: `flash_array_model`

## Requirements
- R1: After reset, every in-range address reads 0xFF, and busy_o, done_o and err_o are 0.
- R2: An accepted erase sets all 64 bytes of the page selected by addr_i[13:6] to 0xFF. Bits addr_i[5:0] are ignored, and bytes of other pages keep their values.
- R3: An accepted program updates the 32-byte row selected by addr_i[13:5], ignoring addr_i[4:0]. Byte j of that row (j = 0..31) is updated only when wr_be_i[j] is 1, and bytes with a 0 enable keep their value.
- R4: For an enabled byte, the new value is the old value ANDed with wr_buf_i[8j+7:8j]. A 1 written over a stored 0 leaves the 0.
- R5: After the clock edge that accepts an erase, busy_o is 1 for exactly 12 cycles; after one that accepts a program, it is 1 for exactly 6 cycles. The contents change at the edge where busy_o falls, and done_o is 1 for exactly the one cycle after that edge.
- R6: While busy_o is 1, rd_data_o is 0xFF for any address.
- R7: A strobe that arrives while busy_o is 1 has no effect on contents, on busy length or on err_o.
- R8: When erase_req_i and prog_req_i are both 1 in an accepting cycle, only the erase is performed.
- R9: A strobe with addr_i at or above the array size (512 by default) starts no operation and sets err_o from the next cycle. The next accepted command clears err_o. Out-of-range reads return 0xFF.
- R10: The write buffer and enables are captured when the program is accepted. Later changes to wr_buf_i or wr_be_i do not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 14 | Byte address for reads and command target |
| rd_data_o | output | 8 | Byte at addr_i, or 0xFF when busy or out of range |
| wr_buf_i | input | 256 | Row data; byte j at bits 8j+7:8j |
| wr_be_i | input | 32 | Per-byte program enables |
| erase_req_i | input | 1 | Erase strobe |
| prog_req_i | input | 1 | Program strobe |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last command was refused for its address |

## Verification
- **Corrupted cell contents:** a wrong cell value stays hidden until that byte is read. For this reason, the whole array is swept through the read port after every operation, and a corrupted byte surfaces within one sweep.
- **Counter or latch faults:** a fault in the busy counter or the latched command state shows up at the ports within the same operation. It appears as a busy edge in the wrong cycle, a misplaced done pulse, or a page or row other than the addressed one being changed.
- **Leaked inputs during busy:** strobes and buffer changes are injected while busy is high. Any leak of those inputs into the stored state appears in the next sweep.

// File: rtl/flash_pkg.sv
package flash_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_ERASE = 2'd1,
      OP_PROG  = 2'd2
   } flash_op_e;

endpackage

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
   import flash_pkg::*;
#(
   parameter int ADDR_W        = 14,
   parameter int ARRAY_BYTES   = 512,
   parameter int ROW_BYTES     = 32,
   parameter int ERASE_CYCLES  = 12,
   parameter int PROG_CYCLES   = 6
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [ADDR_W-1:0]             addr_i,
   input  logic                          erase_req_i,
   input  logic                          prog_req_i,
   input  logic [ROW_BYTES*BYTE_W-1:0]   wr_buf_i,
   input  logic [ROW_BYTES-1:0]          wr_be_i,
   output logic                          busy_o,
   output logic                          done_o,
   output logic                          err_o,
   output logic                          commit_o,
   output flash_op_e                     op_o,
   output logic [ADDR_W-$clog2(ROW_BYTES)-1:0] row_o,
   output logic [ROW_BYTES*BYTE_W-1:0]   buf_o,
   output logic [ROW_BYTES-1:0]          be_o
);

   localparam int ROW_SH    = $clog2(ROW_BYTES);
   localparam int ROW_IX_W  = ADDR_W - ROW_SH;
   localparam int MAX_CYC   = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
   localparam int CNT_W     = $clog2(MAX_CYC + 1);

   logic                        busy_q, done_q, err_q;
   logic [CNT_W-1:0]            cnt_q;
   flash_op_e                   op_q;
   logic [ROW_IX_W-1:0]         row_q;
   logic [ROW_BYTES*BYTE_W-1:0] buf_q;
   logic [ROW_BYTES-1:0]        be_q;
   logic                        in_range, any_req, accept, reject, finish;

   generate
      if (ARRAY_BYTES == (1 << ADDR_W)) begin : g_full_space
         assign in_range = 1'b1;
      end else begin : g_partial_space
         assign in_range = ({1'b0, addr_i} < (ADDR_W+1)'(ARRAY_BYTES));
      end
   endgenerate

   assign any_req = erase_req_i | prog_req_i;
   assign accept  = !busy_q && any_req && in_range;
   assign reject  = !busy_q && any_req && !in_range;
   assign finish  = busy_q && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
         cnt_q  <= '0;
         op_q   <= OP_IDLE;
         row_q  <= '0;
         buf_q  <= '0;
         be_q   <= '0;
      end else begin
         done_q <= finish;
         if (accept) begin
            busy_q <= 1'b1;
            err_q  <= 1'b0;
            row_q  <= addr_i[ADDR_W-1:ROW_SH];
            if (erase_req_i) begin
               op_q  <= OP_ERASE;
               cnt_q <= CNT_W'(ERASE_CYCLES - 1);
            end else begin
               op_q  <= OP_PROG;
               cnt_q <= CNT_W'(PROG_CYCLES - 1);
               buf_q <= wr_buf_i;
               be_q  <= wr_be_i;
            end
         end else if (reject) begin
            err_q <= 1'b1;
         end else if (finish) begin
            busy_q <= 1'b0;
            op_q   <= OP_IDLE;
         end else if (busy_q) begin
            cnt_q <= cnt_q - CNT_W'(1);
         end
      end
   end

   assign busy_o   = busy_q;
   assign done_o   = done_q;
   assign err_o    = err_q;
   assign commit_o = finish;
   assign op_o     = op_q;
   assign row_o    = row_q;
   assign buf_o    = buf_q;
   assign be_o     = be_q;

   assert_busy_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && (cnt_q != '0) |=> busy_q);

   assert_done_after_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> !busy_q && $past(busy_q));

   assert_latched_cmd_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && !finish |=> $stable(row_q) && $stable(op_q) && $stable(buf_q) && $stable(be_q));

   assert_reject_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
      reject |=> !busy_q && err_q);

endmodule

// File: rtl/flash_cell_array.sv
module flash_cell_array
   import flash_pkg::*;
#(
   parameter int ADDR_W        = 14,
   parameter int ARRAY_BYTES   = 512,
   parameter int ROW_BYTES     = 32,
   parameter int ROWS_PER_PAGE = 2
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               commit_i,
   input  flash_op_e                          op_i,
   input  logic [ADDR_W-$clog2(ROW_BYTES)-1:0] row_i,
   input  logic [ROW_BYTES*BYTE_W-1:0]        buf_i,
   input  logic [ROW_BYTES-1:0]               be_i,
   input  logic [ADDR_W-1:0]                  rd_addr_i,
   output logic [BYTE_W-1:0]                  rd_data_o
);

   localparam int PAGE_BYTES = ROW_BYTES * ROWS_PER_PAGE;
   localparam int ROW_SH     = $clog2(ROW_BYTES);
   localparam int RPP_SH     = $clog2(ROWS_PER_PAGE);
   localparam int ROW_IX_W   = ADDR_W - ROW_SH;
   localparam int PAGE_IX_W  = ROW_IX_W - RPP_SH;
   localparam int BYTE_IX_W  = $clog2(ARRAY_BYTES);

   logic [ARRAY_BYTES*BYTE_W-1:0] flat;
   logic [PAGE_IX_W-1:0]          page_sel;
   logic                          do_erase, do_prog;
   logic [BYTE_IX_W-1:0]          byte_ix;
   logic                          rd_in_range;

   assign page_sel = row_i[ROW_IX_W-1:RPP_SH];
   assign do_erase = commit_i && (op_i == OP_ERASE);
   assign do_prog  = commit_i && (op_i == OP_PROG);

   generate
      for (genvar b = 0; b < ARRAY_BYTES; b++) begin : g_cell
         localparam int ROW_IX  = b / ROW_BYTES;
         localparam int PAGE_IX = b / PAGE_BYTES;
         localparam int LANE    = b % ROW_BYTES;
         logic [BYTE_W-1:0] cell_q;
         logic              hit_erase, hit_prog;

         assign hit_erase = do_erase && (page_sel == PAGE_IX_W'(PAGE_IX));
         assign hit_prog  = do_prog && (row_i == ROW_IX_W'(ROW_IX)) && be_i[LANE];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cell_q <= '1;
            else if (hit_erase)
               cell_q <= '1;
            else if (hit_prog)
               cell_q <= cell_q & buf_i[LANE*BYTE_W +: BYTE_W];
         end

         assign flat[b*BYTE_W +: BYTE_W] = cell_q;
      end
   endgenerate

   assign byte_ix     = rd_addr_i[BYTE_IX_W-1:0];
   assign rd_in_range = ({1'b0, rd_addr_i} < (ADDR_W+1)'(ARRAY_BYTES));
   assign rd_data_o   = rd_in_range ? flat[{byte_ix, 3'b000} +: BYTE_W] : '1;

   assert_prog_only_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      do_prog |=> ((flat & ~$past(flat)) == '0));

   assert_contents_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !commit_i |=> (flat == $past(flat)));

endmodule

// File: rtl/flash_array_model.sv
module flash_array_model
   import flash_pkg::*;
#(
   parameter int ADDR_W        = 14,
   parameter int ARRAY_BYTES   = 512,
   parameter int ROW_BYTES     = 32,
   parameter int ROWS_PER_PAGE = 2,
   parameter int ERASE_CYCLES  = 12,
   parameter int PROG_CYCLES   = 6
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [ADDR_W-1:0]           addr_i,
   output logic [7:0]                  rd_data_o,
   input  logic [ROW_BYTES*8-1:0]      wr_buf_i,
   input  logic [ROW_BYTES-1:0]        wr_be_i,
   input  logic                        erase_req_i,
   input  logic                        prog_req_i,
   output logic                        busy_o,
   output logic                        done_o,
   output logic                        err_o
);

   localparam int PAGE_BYTES = ROW_BYTES * ROWS_PER_PAGE;
   localparam int ROW_IX_W   = ADDR_W - $clog2(ROW_BYTES);

   generate
      if ((ROW_BYTES < 1) || ((ROW_BYTES & (ROW_BYTES - 1)) != 0)) begin : g_bad_row
         $error("ROW_BYTES must be a power of two");
      end
      if ((ROWS_PER_PAGE < 1) || ((ROWS_PER_PAGE & (ROWS_PER_PAGE - 1)) != 0)) begin : g_bad_rpp
         $error("ROWS_PER_PAGE must be a power of two");
      end
      if ((ARRAY_BYTES < PAGE_BYTES) || ((ARRAY_BYTES % PAGE_BYTES) != 0)) begin : g_bad_size
         $error("ARRAY_BYTES must be a whole number of pages");
      end
      if (ARRAY_BYTES > (1 << ADDR_W)) begin : g_bad_addr
         $error("ADDR_W too narrow for ARRAY_BYTES");
      end
      if ((ERASE_CYCLES < 1) || (PROG_CYCLES < 1)) begin : g_bad_cyc
         $error("busy durations must be at least one cycle");
      end
   endgenerate

   logic                  commit;
   flash_op_e             op;
   logic [ROW_IX_W-1:0]   row;
   logic [ROW_BYTES*8-1:0] lat_buf;
   logic [ROW_BYTES-1:0]  lat_be;
   logic [7:0]            arr_rd;
   logic                  busy;

   flash_cmd_ctrl #(
      .ADDR_W       (ADDR_W),
      .ARRAY_BYTES  (ARRAY_BYTES),
      .ROW_BYTES    (ROW_BYTES),
      .ERASE_CYCLES (ERASE_CYCLES),
      .PROG_CYCLES  (PROG_CYCLES)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .addr_i      (addr_i),
      .erase_req_i (erase_req_i),
      .prog_req_i  (prog_req_i),
      .wr_buf_i    (wr_buf_i),
      .wr_be_i     (wr_be_i),
      .busy_o      (busy),
      .done_o      (done_o),
      .err_o       (err_o),
      .commit_o    (commit),
      .op_o        (op),
      .row_o       (row),
      .buf_o       (lat_buf),
      .be_o        (lat_be)
   );

   flash_cell_array #(
      .ADDR_W        (ADDR_W),
      .ARRAY_BYTES   (ARRAY_BYTES),
      .ROW_BYTES     (ROW_BYTES),
      .ROWS_PER_PAGE (ROWS_PER_PAGE)
   ) u_cells (
      .clk       (clk),
      .rst_n     (rst_n),
      .commit_i  (commit),
      .op_i      (op),
      .row_i     (row),
      .buf_i     (lat_buf),
      .be_i      (lat_be),
      .rd_addr_i (addr_i),
      .rd_data_o (arr_rd)
   );

   assign busy_o    = busy;
   assign rd_data_o = busy ? 8'hFF : arr_rd;

endmodule

// File: tb/flash_array_model_bench.sv
module flash_array_model_bench;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 14;
   localparam int NB = 512;
   localparam int RB = 32;
   localparam int PB = 64;
   localparam int EC = 12;
   localparam int PC = 6;

   localparam int K_RD   = 0;
   localparam int K_BUSY = 1;
   localparam int K_DONE = 2;
   localparam int K_ERR  = 3;

   typedef struct {
      int         kind;
      logic [7:0] exp;
      string      tag;
   } item_t;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [AW-1:0]   addr = '0;
   logic [7:0]      rd_data;
   logic [RB*8-1:0] wr_buf = '0;
   logic [RB-1:0]   wr_be = '0;
   logic            erase_req = 1'b0;
   logic            prog_req = 1'b0;
   logic            busy, done, err;

   item_t      sb_q[$];
   logic [7:0] model [NB];
   int         vectors = 0;
   int         fails = 0;
   bit         finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_array_model #(
      .ADDR_W(AW), .ARRAY_BYTES(NB), .ROW_BYTES(RB), .ROWS_PER_PAGE(2),
      .ERASE_CYCLES(EC), .PROG_CYCLES(PC)
   ) u_flash_array_model (
      .clk(clk), .rst_n(rst_n), .addr_i(addr), .rd_data_o(rd_data),
      .wr_buf_i(wr_buf), .wr_be_i(wr_be), .erase_req_i(erase_req),
      .prog_req_i(prog_req), .busy_o(busy), .done_o(done), .err_o(err)
   );

   // monitor: pops every item pushed this cycle and compares at the falling edge
   always @(negedge clk) begin
      while (sb_q.size() > 0) begin
         item_t      it;
         logic [7:0] got;
         it = sb_q.pop_front();
         case (it.kind)
            K_RD:    got = rd_data;
            K_BUSY:  got = {7'b0, busy};
            K_DONE:  got = {7'b0, done};
            default: got = {7'b0, err};
         endcase
         vectors++;
         if (got !== it.exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", it.tag, got, it.exp);
         end
      end
   end

   task automatic expect_item(input int kind, input logic [7:0] exp, input string tag);
      item_t it;
      it.kind = kind;
      it.exp  = exp;
      it.tag  = tag;
      sb_q.push_back(it);
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
      @(posedge clk); #1;
      addr = a;
      expect_item(K_RD, exp, tag);
   endtask

   task automatic sweep(input string tag);
      for (int b = 0; b < NB; b++) rd(AW'(b), model[b], tag);
   endtask

   function automatic logic [RB*8-1:0] pattern(input int seed);
      logic [RB*8-1:0] v;
      for (int j = 0; j < RB; j++) v[j*8 +: 8] = 8'((seed * 37 + j * 11) ^ 8'h5A);
      return v;
   endfunction

   // driver: issue one command, follow the busy window, then update the shadow model
   task automatic issue(input bit er, input bit pg, input logic [AW-1:0] a,
                        input logic [RB*8-1:0] bufv, input logic [RB-1:0] bev,
                        input bit inj, input logic [AW-1:0] inj_a, input string tag);
      int n;
      int base;
      n = er ? EC : PC;
      @(posedge clk); #1;
      addr = a; erase_req = er; prog_req = pg; wr_buf = bufv; wr_be = bev;
      @(posedge clk); #1;
      erase_req = 1'b0; prog_req = 1'b0;
      expect_item(K_BUSY, 8'h01, {tag, " R5 busy rises"});
      expect_item(K_ERR, 8'h00, {tag, " R9 err cleared on accept"});
      for (int i = 1; i < n; i++) begin
         @(posedge clk); #1;
         wr_buf = {8{$urandom}};            // R10 buffer changes during busy
         wr_be  = $urandom;
         if (inj && i == 1) begin
            addr = inj_a; erase_req = 1'b1; prog_req = 1'b1;
         end else begin
            addr = AW'($urandom % NB); erase_req = 1'b0; prog_req = 1'b0;
         end
         expect_item(K_RD, 8'hFF, {tag, " R6 read while busy"});
         expect_item(K_BUSY, 8'h01, {tag, " R5 busy held"});
      end
      @(posedge clk); #1;
      erase_req = 1'b0; prog_req = 1'b0;
      expect_item(K_BUSY, 8'h00, {tag, " R5 busy falls"});
      expect_item(K_DONE, 8'h01, {tag, " R5 done pulse"});
      if (inj) expect_item(K_ERR, 8'h00, {tag, " R7 err untouched by busy strobe"});
      if (er) begin
         base = (int'(a) / PB) * PB;
         for (int j = 0; j < PB; j++) model[base + j] = 8'hFF;
      end else begin
         base = (int'(a) / RB) * RB;
         for (int j = 0; j < RB; j++)
            if (bev[j]) model[base + j] = model[base + j] & bufv[j*8 +: 8];
      end
      @(posedge clk); #1;
      expect_item(K_DONE, 8'h00, {tag, " R5 done one cycle"});
   endtask

   initial begin
      for (int b = 0; b < NB; b++) model[b] = 8'hFF;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      expect_item(K_BUSY, 8'h00, "R1 busy after reset");
      expect_item(K_DONE, 8'h00, "R1 done after reset");
      expect_item(K_ERR, 8'h00, "R1 err after reset");
      sweep("R1 erased after reset");

      // R3/R7/R10: program row 2 with an in-range strobe injected while busy
      issue(1'b0, 1'b1, 14'h045, pattern(1), '1, 1'b1, 14'h0C0, "R3 prog row2");
      sweep("R3 R7 R10 after prog row2");

      issue(1'b0, 1'b1, 14'h010, pattern(2), '1, 1'b0, '0, "R3 prog row0");
      issue(1'b0, 1'b1, 14'h09F, pattern(3), '1, 1'b0, '0, "R3 prog row4");
      sweep("R3 rows 0 and 4");

      // R4: reprogram row 2 with alternating enables; ones over zeros stay zero
      issue(1'b0, 1'b1, 14'h05A, pattern(4), 32'h5555_5555, 1'b0, '0, "R4 reprogram");
      sweep("R4 AND-only program");

      // R2: erase page 1 via an unaligned address
      issue(1'b1, 1'b0, 14'h07F, '0, '0, 1'b0, '0, "R2 erase page1");
      sweep("R2 page erase");

      // R8: both strobes -> erase only (page 0 held programmed row 0)
      issue(1'b1, 1'b1, 14'h003, pattern(5), '1, 1'b0, '0, "R8 both strobes");
      sweep("R8 erase wins");

      // R9: out-of-range command refused
      @(posedge clk); #1;
      addr = 14'h200; prog_req = 1'b1; wr_buf = pattern(6); wr_be = '1;
      @(posedge clk); #1;
      prog_req = 1'b0;
      expect_item(K_BUSY, 8'h00, "R9 no busy on refused command");
      expect_item(K_ERR, 8'h01, "R9 err raised");
      @(posedge clk); #1;
      expect_item(K_BUSY, 8'h00, "R9 still idle");
      expect_item(K_ERR, 8'h01, "R9 err sticky");
      rd(14'h3000, 8'hFF, "R9 out-of-range read");
      sweep("R9 nothing changed");

      // R7: out-of-range strobe during busy must not set err
      issue(1'b0, 1'b1, 14'h1E0, pattern(7), '1, 1'b1, 14'h3FFF, "R7 prog row15");
      sweep("R7 R3 after row15");

      @(negedge clk); #1;
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule